// File: doc/BRIEF.md
# Four-Way Age-Counter Replacement Unit

This block keeps the replacement state for a bank of 4-way cache sets. Each way of each set owns a 2-bit age, where 0 is the most recently touched line and 3 the stalest. A cache controller presents one access per cycle: the set number, whether the lookup hit, the way that hit, and the set's current valid bits. The block answers in the same cycle with the way to fill if the access is a miss. At the next clock edge it rewrites that set's four ages.

On a hit, the touched way becomes youngest. Only the ways that were younger than it move one step older. On a miss, the filled way becomes youngest and every other way in the set ages by one step, stopping at 3. The fill way is chosen as follows:

- While the set still has an empty way, the lowest-numbered empty way is used.
- Once the set is full, the oldest way is used.

The ages of the addressed set are also visible on an output, so the controller or a bench can observe them. Tag matching and line storage belong elsewhere.

Top module: `lru4_age_unit`

## Requirements
- R1: After a synchronous reset, every age of every set reads 0.
- R2: On a hit (acc_valid=1, acc_hit=1), the addressed set changes at the next clock edge as follows. The way named by hit_way takes age 0. Each way whose age was below the hit way's old age gains 1. All other ways keep their age.
- R3: way_valid bit i is 1 when way i holds a line. When way_valid is not 4'b1111, fill_way is the lowest-numbered way whose valid bit is 0.
- R4: On a miss in a set that is not full, the fill way takes age 0 and every other way gains 1, saturating at 3.
- R5: On a miss in a full set, fill_way is the way holding the largest age, with the lowest index winning a tie. That way takes age 0 and the others gain 1.
- R6: State changes only at a clock edge where acc_valid is 1. fill_way and age_out follow acc_set and way_valid combinationally.
- R7: An access changes only the addressed set. All other sets keep their ages.
- R8: A set filled by a sequence of misses, and then accessed by hits and misses, holds four distinct ages while it is full.
- R9: age_out carries the age of way i at bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe; updates the addressed set at the next edge |
| acc_set | input | 5 | Set index |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| hit_way | input | 2 | Way that hit |
| way_valid | input | 4 | Per-way valid bits of the addressed set |
| fill_way | output | 2 | Way to load on a miss |
| age_out | output | 8 | Current ages of the addressed set |

## Verification
The main stimulus is a single set taken through four fill misses, repeated hits on the same way, hits on the youngest and the oldest way, and misses that evict from the full set. Together these separate the conditional hit increment from a plain increment of everything, and oldest-way eviction from lowest-index choice. A set that is missed four times while its valid bits stay at zero shows saturation: the untouched ways must stop at 3 rather than wrap to 0. Valid patterns with holes in the middle show that the lowest empty way is chosen. Accesses with the strobe low, and reads of other sets, show that state changes only where and when it should.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
    localparam int WAYS  = 4;
    localparam int AGE_W = 2;
    localparam int WAY_W = 2;

    typedef logic [AGE_W-1:0] age_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef age_t [WAYS-1:0]  age_set_t;

    localparam age_t AGE_MAX = age_t'(WAYS - 1);

    typedef struct packed {
        logic hit;
        way_t hit_way;
        way_t fill_way;
    } access_t;

    function automatic age_t age_step(input age_t a);
        return (a == AGE_MAX) ? a : a + age_t'(1);
    endfunction
endpackage

// File: rtl/lru4_victim_sel.sv
module lru4_victim_sel
    import lru4_pkg::*;
(
    input  age_set_t         ages,
    input  logic [WAYS-1:0]  valid,
    output way_t             fill_way
);
    way_t empty_way;
    way_t old_way;
    logic has_empty;

    always_comb begin
        has_empty = 1'b0;
        empty_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                has_empty = 1'b1;
                empty_way = way_t'(i);
            end
        end
    end

    always_comb begin
        old_way = '0;
        for (int i = 1; i < WAYS; i++) begin
            if (ages[i] > ages[old_way]) old_way = way_t'(i);
        end
    end

    assign fill_way = has_empty ? empty_way : old_way;
endmodule

// File: rtl/lru4_age_update.sv
module lru4_age_update
    import lru4_pkg::*;
(
    input  age_set_t cur,
    input  access_t  acc,
    output age_set_t nxt
);
    age_t ref_age;

    assign ref_age = cur[acc.hit_way];

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            if (acc.hit) begin
                if (way_t'(i) == acc.hit_way) nxt[i] = '0;
                else if (cur[i] < ref_age)    nxt[i] = cur[i] + age_t'(1);
                else                          nxt[i] = cur[i];
            end else begin
                if (way_t'(i) == acc.fill_way) nxt[i] = '0;
                else                           nxt[i] = age_step(cur[i]);
            end
        end
    end
endmodule

// File: rtl/lru4_state_array.sv
module lru4_state_array
    import lru4_pkg::*;
#(
    parameter int SET_W = 5,
    localparam int NUM_SETS = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SET_W-1:0] idx,
    input  age_set_t         wdata,
    output age_set_t         rdata
);
    age_set_t [NUM_SETS-1:0] store;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst)                               store[s] <= '0;
            else if (we && idx == (SET_W)'(s))     store[s] <= wdata;
        end
    end

    assign rdata = store[idx];

    // R1: reset clears the whole array
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> store == '0);

    // R6: no strobe, no change anywhere
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(store));
endmodule

// File: rtl/lru4_age_unit.sv
module lru4_age_unit
    import lru4_pkg::*;
#(
    parameter int SET_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [1:0]       hit_way,
    input  logic [3:0]       way_valid,
    output logic [1:0]       fill_way,
    output logic [7:0]       age_out
);
    age_set_t rd_ages;
    age_set_t wr_ages;
    way_t     victim;
    access_t  acc;

    lru4_state_array #(.SET_W(SET_W)) u_state (
        .clk   (clk),
        .rst   (rst),
        .we    (acc_valid),
        .idx   (acc_set),
        .wdata (wr_ages),
        .rdata (rd_ages)
    );

    lru4_victim_sel u_victim (
        .ages     (rd_ages),
        .valid    (way_valid),
        .fill_way (victim)
    );

    assign acc = '{hit: acc_hit, hit_way: hit_way, fill_way: victim};

    lru4_age_update u_update (
        .cur (rd_ages),
        .acc (acc),
        .nxt (wr_ages)
    );

    assign fill_way = victim;
    assign age_out  = rd_ages;

    // R2: the hit way reads youngest on the following cycle
    p_hit_youngest_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit) |=>
            (acc_set != $past(acc_set)) || (rd_ages[$past(hit_way)] == '0));

    // R4: the filled way reads youngest on the following cycle
    p_fill_youngest_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit) |=>
            (acc_set != $past(acc_set)) || (rd_ages[$past(fill_way)] == '0));

    // R5: in a full set the victim is at least as old as every way
    p_victim_oldest_r5: assert property (@(posedge clk) disable iff (rst)
        (&way_valid) |-> (rd_ages[fill_way] >= rd_ages[0]) &&
                         (rd_ages[fill_way] >= rd_ages[1]) &&
                         (rd_ages[fill_way] >= rd_ages[2]) &&
                         (rd_ages[fill_way] >= rd_ages[3]));

    // R3: a non-full set never picks a valid way
    p_fill_empty_r3: assert property (@(posedge clk) disable iff (rst)
        !(&way_valid) |-> !way_valid[fill_way]);
endmodule

// File: tb/tb_lru4_age_unit.sv
`timescale 1ns/1ps
module tb_lru4_age_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid;
    logic [4:0] acc_set;
    logic       acc_hit;
    logic [1:0] hit_way;
    logic [3:0] way_valid;
    logic [1:0] fill_way;
    logic [7:0] age_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lru4_age_unit dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .hit_way(hit_way), .way_valid(way_valid),
        .fill_way(fill_way), .age_out(age_out)
    );

    // {hit, hit_way, way_valid, expected fill (misses), expected ages {w3,w2,w1,w0}}
    typedef struct packed {
        logic       hit;
        logic [1:0] way;
        logic [3:0] valid;
        logic [1:0] efill;
        logic [7:0] eages;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'b0000, 2'd0, {2'd1,2'd1,2'd1,2'd0}},
        '{1'b0, 2'd0, 4'b0001, 2'd1, {2'd2,2'd2,2'd0,2'd1}},
        '{1'b0, 2'd0, 4'b0011, 2'd2, {2'd3,2'd0,2'd1,2'd2}},
        '{1'b0, 2'd0, 4'b0111, 2'd3, {2'd0,2'd1,2'd2,2'd3}},
        '{1'b1, 2'd1, 4'b1111, 2'd0, {2'd1,2'd2,2'd0,2'd3}},
        '{1'b1, 2'd1, 4'b1111, 2'd0, {2'd1,2'd2,2'd0,2'd3}},
        '{1'b0, 2'd0, 4'b1111, 2'd0, {2'd2,2'd3,2'd1,2'd0}},
        '{1'b1, 2'd0, 4'b1111, 2'd0, {2'd2,2'd3,2'd1,2'd0}},
        '{1'b1, 2'd2, 4'b1111, 2'd0, {2'd3,2'd0,2'd2,2'd1}},
        '{1'b0, 2'd0, 4'b1111, 2'd3, {2'd0,2'd1,2'd3,2'd2}},
        '{1'b1, 2'd3, 4'b1111, 2'd0, {2'd0,2'd1,2'd3,2'd2}},
        '{1'b1, 2'd1, 4'b1111, 2'd0, {2'd1,2'd2,2'd0,2'd3}}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_hit = 0; hit_way = 0;
    endtask

    // drive at negedge, let one edge pass, return at the next negedge
    task automatic access(input logic [4:0] s, input logic h, input logic [1:0] w,
                          input logic [3:0] v);
        acc_set = s; acc_hit = h; hit_way = w; way_valid = v; acc_valid = 1;
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    function automatic bit distinct(input logic [7:0] a);
        return a[1:0] != a[3:2] && a[1:0] != a[5:4] && a[1:0] != a[7:6] &&
               a[3:2] != a[5:4] && a[3:2] != a[7:6] && a[5:4] != a[7:6];
    endfunction

    initial begin
        #(20ns * 5000);
        if (!finished) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; idle(); acc_set = 0; way_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;

        // R1: reset state on several sets
        acc_set = 5'd0;  #1; check("R1", age_out, 8'h00);
        acc_set = 5'd31; #1; check("R1", age_out, 8'h00);

        // R2 R4 R5 R9: table walk on set 5
        for (int k = 0; k < NV; k++) begin
            acc_set = 5'd5; acc_hit = VECS[k].hit; hit_way = VECS[k].way;
            way_valid = VECS[k].valid; #1;
            if (!VECS[k].hit) check(VECS[k].valid == 4'hf ? "R5 fill" : "R3 fill",
                                    {6'd0, fill_way}, {6'd0, VECS[k].efill});
            access(5'd5, VECS[k].hit, VECS[k].way, VECS[k].valid);
            check(VECS[k].hit ? "R2" : (VECS[k].valid == 4'hf ? "R5" : "R4"),
                  age_out, VECS[k].eages);
            if (VECS[k].valid == 4'hf)
                check("R8 distinct", {7'd0, distinct(age_out)}, 8'd1);
        end

        // R6: strobe low, hit stimulus present, nothing changes
        acc_set = 5'd5; acc_hit = 1; hit_way = 2'd2; way_valid = 4'hf; acc_valid = 0;
        @(posedge clk); @(negedge clk); #1;
        check("R6 no strobe", age_out, {2'd1,2'd2,2'd0,2'd3});

        // R4: saturation, set 2 missed four times with no valid ways
        for (int k = 0; k < 4; k++) begin
            acc_set = 5'd2; way_valid = 4'b0000; #1;
            check("R3 fill", {6'd0, fill_way}, 8'd0);
            access(5'd2, 1'b0, 2'd0, 4'b0000);
        end
        check("R4 saturate", age_out, {2'd3,2'd3,2'd3,2'd0});

        // R7: set 5 untouched by set 2 traffic
        acc_set = 5'd5; #1;
        check("R7", age_out, {2'd1,2'd2,2'd0,2'd3});

        // R3: lowest empty way with holes
        acc_set = 5'd9; way_valid = 4'b1010; #1;
        check("R3 1010", {6'd0, fill_way}, 8'd0);
        way_valid = 4'b1011; #1;
        check("R3 1011", {6'd0, fill_way}, 8'd2);
        way_valid = 4'b1101; #1;
        check("R3 1101", {6'd0, fill_way}, 8'd1);
        access(5'd9, 1'b0, 2'd0, 4'b1101);
        check("R4 R9", age_out, {2'd1,2'd1,2'd0,2'd1});

        // R1: reset mid-run clears used sets
        @(negedge clk); rst = 1; @(posedge clk); @(negedge clk); rst = 0; #1;
        acc_set = 5'd5; #1; check("R1 rerun", age_out, 8'h00);
        acc_set = 5'd2; #1; check("R1 rerun", age_out, 8'h00);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule